// File: doc/BRIEF.md
# Dual Cascadable Interval Timer

This block holds two down-counting interval timers that share one control word. Each timer takes its count step from one of several tick sources: a fast tick, a slow tick, the output of a programmable prescaler or, for the second timer, the underflow of the first. A timer can be held with its divider preloaded, or left to run. When a running timer passes its last count, it reloads its divider and latches a pending interrupt flag. Software acknowledges the flag by writing the control word with that timer's acknowledge bit set.

The tick sources reach the block as single-cycle enable pulses in the core clock domain. A mask register decides which pending flags drive the shared interrupt line. The live counts of both timers and of the prescaler can be read at any time. When the second timer is chained, the pair counts as one long divider: the first timer supplies the low digit and the second the high digit.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both timer counts read 256, the prescaler count reads 0, both pending flags and the interrupt line are 0, and both timers are in hold mode.
- R2: A 24-bit control word holds timer 0 in bits [11:0] and timer 1 in bits [23:12]. Within each 12-bit field, bits [7:0] are the divider, bit 8 is the mode (0 hold, 1 run), bit 9 is acknowledge and bits [11:10] are the tick select. The written word takes effect one cycle after the write. In hold mode the count is loaded with the divider on every cycle and does not change with ticks.
- R3: In run mode each selected tick lowers the count by one. A tick that arrives at count 1 reloads the divider in the same edge and sets the timer's pending flag, so the timer underflows once every divider ticks.
- R4: Tick select 0 picks the fast tick, 1 the slow tick and 2 the prescaler tick. For timer 0, select 3 picks no tick. A timer ignores ticks from sources it has not selected.
- R5: For timer 1, tick select 3 chains it to timer 0: timer 1 steps once on each timer 0 underflow, in the same cycle.
- R6: A write to the prescaler reload register loads both the reload value and the prescaler count. Each fast tick lowers the count by one. A fast tick at count 1 or 0 reloads the count and issues one prescaler tick.
- R7: A control write with a timer's acknowledge bit set to 1 clears that timer's pending flag. With the bit at 0, the flag is left unchanged.
- R8: If an underflow and an acknowledge of the same timer fall in the same cycle, the pending flag stays set.
- R9: A 2-bit mask register (bit 0 timer 0, bit 1 timer 1) is written whole. The interrupt line is high exactly when some pending flag has its mask bit set.
- R10: A divider of 0 counts as 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_fast | input | 1 | Fast tick enable pulse |
| tick_slow | input | 1 | Slow tick enable pulse |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 24 | Control word write data |
| presc_we | input | 1 | Prescaler reload write strobe |
| presc_wdata | input | PRESC_W | Prescaler reload value |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_wdata | input | 2 | Interrupt mask value |
| cnt0 | output | 9 | Live count of timer 0 |
| cnt1 | output | 9 | Live count of timer 1 |
| presc_cnt | output | PRESC_W | Live prescaler count |
| pend | output | 2 | Pending interrupt flags |
| irq | output | 1 | Masked interrupt output |

## Verification
An underflow and a software acknowledge of the same timer can fall in the same cycle. Both change the pending flag, so the block must give the set priority, or an interrupt is lost. The bench programs timer 0 with a divider of 1, so that every fast tick is an underflow. It then drives a control write with the acknowledge bit together with a fast tick, and requires the flag to read 1 afterwards. An acknowledge written alone then has to clear the flag. A second overlap, a timer 0 underflow stepping a chained timer 1 in the same edge, is judged by the counts read back after a known number of fast ticks.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int DIV_W   = 8;
  localparam int CNT_W   = DIV_W + 1;
  localparam int FIELD_W = DIV_W + 4;
  localparam int N_TMR   = 2;
  localparam int CTRL_W  = N_TMR * FIELD_W;
  localparam int ACK_BIT = DIV_W + 1;
  localparam int RUN_BIT = DIV_W;

  typedef enum logic [1:0] {
    SEL_FAST  = 2'd0,
    SEL_SLOW  = 2'd1,
    SEL_PRESC = 2'd2,
    SEL_CHAIN = 2'd3
  } tick_sel_e;

  typedef struct packed {
    tick_sel_e        sel;
    logic             run;
    logic [DIV_W-1:0] div;
  } tmr_cfg_t;

  // Divider field to reload value; zero stands for the full range.
  function automatic logic [CNT_W-1:0] load_of(input logic [DIV_W-1:0] div);
    if (div == '0) return CNT_W'(1 << DIV_W);
    return {1'b0, div};
  endfunction

  // Extract the stored part of one timer's control field.
  function automatic tmr_cfg_t cfg_of(input logic [FIELD_W-1:0] f);
    tmr_cfg_t c;
    c.sel = tick_sel_e'(f[FIELD_W-1 -: 2]);
    c.run = f[RUN_BIT];
    c.div = f[DIV_W-1:0];
    return c;
  endfunction

  // Next count of a running timer on a tick.
  function automatic logic [CNT_W-1:0] step_of(input logic [CNT_W-1:0] cnt,
                                               input logic [CNT_W-1:0] load);
    if (cnt <= CNT_W'(1)) return load;
    return cnt - CNT_W'(1);
  endfunction
endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_in,
  input  logic          we,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] cnt_o,
  output logic          tick_o
);
  logic [PW-1:0] reload_q;
  logic [PW-1:0] cnt_q;
  logic          at_end;

  assign at_end = cnt_q <= PW'(1);
  assign tick_o = tick_in && at_end && !we;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (we) begin
      reload_q <= wdata;
      cnt_q    <= wdata;
    end else if (tick_in) begin
      cnt_q <= at_end ? reload_q : cnt_q - PW'(1);
    end
  end
endmodule

// File: rtl/dit_timer.sv
module dit_timer
  import dit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_cfg_t         cfg,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic             tick_presc,
  input  logic             tick_chain,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load;
  logic             tick;

  assign load = load_of(cfg.div);

  always_comb begin
    case (cfg.sel)
      SEL_FAST:  tick = tick_fast;
      SEL_SLOW:  tick = tick_slow;
      SEL_PRESC: tick = tick_presc;
      default:   tick = tick_chain;
    endcase
  end

  assign uf_o  = cfg.run && tick && (cnt_q <= CNT_W'(1));
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= load_of('0);
    else if (!cfg.run) cnt_q <= load;
    else if (tick)     cnt_q <= step_of(cnt_q, load);
  end
endmodule

// File: rtl/dit_pend.sv
module dit_pend #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] uf,
  input  logic [N-1:0] ack,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] mask_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q[i] <= 1'b0;
      else if (uf[i])  pend_q[i] <= 1'b1;
      else if (ack[i]) pend_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = |(pend_q & mask_q);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_fast,
  input  logic               tick_slow,
  input  logic               ctrl_we,
  input  logic [CTRL_W-1:0]  ctrl_wdata,
  input  logic               presc_we,
  input  logic [PRESC_W-1:0] presc_wdata,
  input  logic               mask_we,
  input  logic [N_TMR-1:0]   mask_wdata,
  output logic [CNT_W-1:0]   cnt0,
  output logic [CNT_W-1:0]   cnt1,
  output logic [PRESC_W-1:0] presc_cnt,
  output logic [N_TMR-1:0]   pend,
  output logic               irq
);
  tmr_cfg_t         cfg_q [N_TMR];
  logic [CNT_W-1:0] cnt   [N_TMR];
  logic [N_TMR-1:0] uf;
  logic [N_TMR-1:0] ack;
  logic [N_TMR-1:0] run_q;
  logic [N_TMR-1:0] mask_q;
  logic             presc_tick;
  logic             chain1;

  dit_prescaler #(.PW(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_fast),
    .we(presc_we), .wdata(presc_wdata),
    .cnt_o(presc_cnt), .tick_o(presc_tick)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    logic [FIELD_W-1:0] fld;
    logic               chain_in;
    assign fld    = ctrl_wdata[i*FIELD_W +: FIELD_W];
    assign ack[i] = ctrl_we && fld[ACK_BIT];
    assign run_q[i] = cfg_q[i].run;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q[i] <= '0;
      else if (ctrl_we) cfg_q[i] <= cfg_of(fld);
    end

    if (i == 0) begin : g_head
      assign chain_in = 1'b0;
    end else begin : g_link
      assign chain_in = uf[i-1];
    end

    dit_timer u_tmr (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q[i]),
      .tick_fast(tick_fast), .tick_slow(tick_slow),
      .tick_presc(presc_tick), .tick_chain(chain_in),
      .cnt_o(cnt[i]), .uf_o(uf[i])
    );
  end

  assign chain1 = (cfg_q[1].sel == SEL_CHAIN);

  dit_pend #(.N(N_TMR)) u_pend (
    .clk(clk), .rst_n(rst_n), .uf(uf), .ack(ack),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .pend_o(pend), .mask_o(mask_q), .irq_o(irq)
  );

  assign cnt0 = cnt[0];
  assign cnt1 = cnt[1];
endmodule

// File: rtl/dit_checker.sv
module dit_checker
  import dit_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_we,
  input logic [CTRL_W-1:0] ctrl_wdata,
  input logic [N_TMR-1:0]  run_q,
  input logic              chain1,
  input logic [N_TMR-1:0]  uf,
  input logic [N_TMR-1:0]  pend,
  input logic [N_TMR-1:0]  mask_q,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CNT_W-1:0]  cnt1
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1 << DIV_W);

  AST_UF_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    uf[0] |=> pend[0]); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[ACK_BIT] && !uf[0]) |=> !pend[0]); // R7

  AST_IRQ_NEEDS_MASKED_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend & mask_q) != '0)); // R9

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 != '0) && (cnt0 <= FULL) && (cnt1 != '0) && (cnt1 <= FULL)); // R10

  AST_HOLD_NO_UF: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q[0] |-> !uf[0]); // R2

  AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (chain1 && run_q[1] && uf[0] && cnt1 > CNT_W'(1))
      |=> (cnt1 == CNT_W'($past(cnt1) - CNT_W'(1)))); // R5
endmodule

bind dual_interval_timer dit_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
  .run_q(run_q), .chain1(chain1), .uf(uf), .pend(pend), .mask_q(mask_q),
  .irq(irq), .cnt0(cnt0), .cnt1(cnt1)
);

// File: tb/tb_dual_interval_timer.sv
`timescale 1ns/1ps
module tb_dual_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_fast = 0, tick_slow = 0;
  logic        ctrl_we = 0, presc_we = 0, mask_we = 0;
  logic [23:0] ctrl_wdata = '0;
  logic [15:0] presc_wdata = '0;
  logic [1:0]  mask_wdata = '0;
  logic [8:0]  cnt0, cnt1;
  logic [15:0] presc_cnt;
  logic [1:0]  pend;
  logic        irq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dual_interval_timer dut (.*);

  localparam int NV = 9;
  localparam int V_DIV [NV] = '{5, 5, 5, 5, 1, 1, 0, 250, 3};
  localparam int V_N   [NV] = '{3, 4, 5, 7, 1, 0, 2, 250, 6};
  localparam int V_CNT [NV] = '{2, 1, 5, 3, 1, 1, 254, 250, 3};
  localparam int V_PND [NV] = '{0, 0, 1, 1, 1, 0, 0, 1, 1};

  function automatic logic [11:0] fld(int div, bit run, bit ack, int sel);
    return {sel[1:0], ack, run, div[7:0]};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [11:0] t1, logic [11:0] t0);
    ctrl_we = 1; ctrl_wdata = {t1, t0};
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic fast(int n);
    repeat (n) begin
      tick_fast = 1; @(negedge clk); tick_fast = 0;
    end
  endtask

  task automatic wr_mask(logic [1:0] m);
    mask_we = 1; mask_wdata = m; @(negedge clk); mask_we = 0;
  endtask

  initial begin
    #1ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt0", cnt0, 256);
    chk("R1 cnt1", cnt1, 256);
    chk("R1 presc", presc_cnt, 0);
    chk("R1 pend", pend, 0);
    chk("R1 irq", irq, 0);

    // R3 table of fast-tick runs on timer 0
    for (int v = 0; v < NV; v++) begin
      wr_ctrl(fld(0, 0, 1, 0), fld(V_DIV[v], 0, 1, 0));
      idle(1);
      wr_ctrl(fld(0, 0, 0, 0), fld(V_DIV[v], 1, 0, 0));
      fast(V_N[v]);
      chk($sformatf("R3 cnt0 vec%0d", v), cnt0, V_CNT[v]);
      chk($sformatf("R3 pend0 vec%0d", v), pend[0], V_PND[v]);
    end

    // R2 and R10: hold mode with divider 0 ignores ticks
    wr_ctrl(fld(0, 0, 1, 0), fld(0, 0, 1, 0));
    idle(1);
    chk("R10 cnt0 hold div0", cnt0, 256);
    fast(3);
    chk("R2 cnt0 hold ignores ticks", cnt0, 256);
    chk("R2 no pend in hold", pend[0], 0);

    // R4 slow select ignores fast ticks
    wr_ctrl(fld(0, 0, 1, 0), fld(4, 0, 1, 1));
    idle(1);
    wr_ctrl(fld(0, 0, 0, 0), fld(4, 1, 0, 1));
    fast(3);
    chk("R4 slow sel ignores fast", cnt0, 4);
    tick_slow = 1; @(negedge clk); tick_slow = 0;
    chk("R4 slow tick steps", cnt0, 3);

    // R6 prescaler feeding timer 0
    wr_ctrl(fld(0, 0, 1, 0), fld(2, 0, 1, 2));
    idle(1);
    wr_ctrl(fld(0, 0, 0, 0), fld(2, 1, 0, 2));
    presc_we = 1; presc_wdata = 16'd3; @(negedge clk); presc_we = 0;
    chk("R6 presc loaded", presc_cnt, 3);
    fast(1);
    chk("R6 presc steps", presc_cnt, 2);
    fast(5);
    chk("R6 presc reloads", presc_cnt, 3);
    chk("R6 cnt0 after two presc ticks", cnt0, 2);
    chk("R6 pend0 after presc underflow", pend[0], 1);

    // R5 chained timer 1
    wr_ctrl(fld(3, 0, 1, 3), fld(2, 0, 1, 0));
    idle(1);
    wr_ctrl(fld(3, 1, 0, 3), fld(2, 1, 0, 0));
    fast(4);
    chk("R5 cnt1 after two uf0", cnt1, 1);
    chk("R5 pend1 not yet", pend[1], 0);
    fast(2);
    chk("R5 cnt1 reload", cnt1, 3);
    chk("R5 pend1 set", pend[1], 1);

    // R7 ack bit at 0 leaves flag; R9 masking
    wr_ctrl(fld(3, 1, 0, 3), fld(2, 1, 0, 0));
    chk("R7 nop keeps pend1", pend[1], 1);
    chk("R9 irq masked", irq, 0);
    wr_mask(2'b10);
    chk("R9 irq unmasked", irq, 1);
    wr_ctrl(fld(3, 1, 1, 3), fld(2, 1, 0, 0));
    chk("R7 ack clears pend1", pend[1], 0);
    chk("R7 pend0 untouched", pend[0], 1);
    chk("R9 irq drops", irq, 0);
    wr_mask(2'b01);
    chk("R9 irq from timer0", irq, 1);

    // R8 underflow and ack in one cycle
    wr_ctrl(fld(0, 0, 1, 0), fld(1, 0, 1, 0));
    idle(1);
    wr_ctrl(fld(0, 0, 0, 0), fld(1, 1, 0, 0));
    fast(1);
    chk("R8 pend0 set", pend[0], 1);
    ctrl_we = 1; ctrl_wdata = {fld(0, 0, 0, 0), fld(1, 1, 1, 0)}; tick_fast = 1;
    @(negedge clk);
    ctrl_we = 0; tick_fast = 0;
    chk("R8 set wins over ack", pend[0], 1);
    wr_ctrl(fld(0, 0, 0, 0), fld(1, 1, 1, 0));
    chk("R8 ack alone clears", pend[0], 0);
    chk("R9 irq low", irq, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule